// File: doc/BRIEF.md
# Masked Vector Register ALU

This block is a small vector execution unit. It holds a bank of vector registers of 64 elements each and a bank of 64-bit scalar registers. One instruction is accepted at a time through a valid/ready handshake. The instruction set covers writing an immediate into a scalar register, loading a vector from a contiguous memory block, storing a vector to a contiguous memory block, adding two vectors element by element, and a predicated add. In the predicated add, a scalar register acts as a per-element mask.

Work proceeds in overlapped beats of several elements each. A memory beat carries as many elements as the bus is wide, and the adder handles the same number of lanes per cycle, so the cycle count of every vector instruction follows from the bus width. A one-cycle done pulse closes each instruction. The unit takes no new instruction until that pulse.

Top module: `vec_mask_alu`

## Requirements
- R1: After reset, instr_ready is 1, done is 0 and mem_req is 0. Every vector register element and every scalar register reads as zero.
- R2: An instruction is taken on a clock edge where instr_valid and instr_ready are both 1. While a vector instruction runs, instr_ready stays 0 and instr_valid is ignored.
- R3: Op code 1 (load) fills register instr_vd with the 64 words at instr_addr+i, for i from 0 to 63. It uses 16 beats. Beat k drives mem_addr = instr_addr+4k, and lane j of mem_rdata (bits 16j+15..16j) holds the word at mem_addr+j.
- R4: Op code 2 (store) writes register instr_vs1 to the words at instr_addr+i, for i from 0 to 63. It uses the same beat and lane layout as R3, with mem_we and mem_req both 1.
- R5: Op code 3 (add) sets element i of instr_vd to element i of instr_vs1 plus element i of instr_vs2, modulo 2^16.
- R6: Op code 4 (masked add) does the same as R5 only for those i where bit i of scalar register instr_sr is 1. Every other element of instr_vd keeps its previous value.
- R7: Op code 0 writes instr_imm into scalar register instr_sr.
- R8: done is a single-cycle pulse. It is high in the cycle right after the accepting edge for op codes 0, 5, 6 and 7, and 16 cycles after the accepting edge for op codes 1 to 4.
- R9: A destination register may also be one of the sources of an add, and the result is still element-wise correct.
- R10: Op codes 5, 6 and 7 change no register and make no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Unit idle, instruction can be taken |
| instr_op | input | 3 | Op code |
| instr_vd | input | 2 | Destination vector register |
| instr_vs1 | input | 2 | First source vector register (store source) |
| instr_vs2 | input | 2 | Second source vector register |
| instr_sr | input | 2 | Scalar register (mask or immediate target) |
| instr_addr | input | 16 | Element base address for load and store |
| instr_imm | input | 64 | Immediate for scalar write |
| mem_req | output | 1 | Memory beat active |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 16 | Address of lane 0 of the beat |
| mem_wdata | output | 64 | Store data, four 16-bit lanes |
| mem_rdata | input | 64 | Load data for the current beat, four lanes |
| done | output | 1 | Instruction complete pulse |

## Verification
The bench aims at the mask extremes: all-zero, all-one and random masks. A design that inverts or misaligns the mask per beat would overwrite elements that must stay. Unaligned base addresses and additions that overflow 16 bits expose lane ordering and carry-width mistakes. Destination-equals-source adds catch a design that reads after its own write. Instructions offered during a busy load, and undefined op codes, catch a unit that takes work too early or that lets an undefined code alter state.

// File: rtl/vmu_pkg.sv
package vmu_pkg;
  typedef enum logic [2:0] {
    OP_SETS  = 3'd0,
    OP_VLD   = 3'd1,
    OP_VST   = 3'd2,
    OP_VADD  = 3'd3,
    OP_VADDM = 3'd4
  } vop_e;

  function automatic logic is_vec_op(input logic [2:0] op);
    return (op == OP_VLD) || (op == OP_VST) || (op == OP_VADD) || (op == OP_VADDM);
  endfunction

  function automatic logic is_mem_op(input logic [2:0] op);
    return (op == OP_VLD) || (op == OP_VST);
  endfunction

  function automatic logic is_add_op(input logic [2:0] op);
    return (op == OP_VADD) || (op == OP_VADDM);
  endfunction
endpackage

// File: rtl/vmu_ctrl.sv
module vmu_ctrl #(
  parameter int AW     = 16,
  parameter int BEAT   = 4,
  parameter int BEAT_N = 16,
  parameter int CW     = 4,
  parameter int VI     = 2,
  parameter int SI     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic [2:0]    instr_op,
  input  logic [VI-1:0] instr_vd,
  input  logic [VI-1:0] instr_vs1,
  input  logic [VI-1:0] instr_vs2,
  input  logic [SI-1:0] instr_sr,
  input  logic [AW-1:0] instr_addr,
  output logic          instr_ready,
  output logic          accept,
  output logic          busy,
  output logic          last_beat,
  output logic [CW-1:0] beat,
  output logic [2:0]    op_q,
  output logic [VI-1:0] vd_q,
  output logic [VI-1:0] vs1_q,
  output logic [VI-1:0] vs2_q,
  output logic [SI-1:0] sr_q,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic          done
);
  import vmu_pkg::*;

  logic [AW-1:0] addr_q;

  assign instr_ready = !busy;
  assign accept      = instr_valid && !busy;
  assign last_beat   = busy && (beat == CW'(BEAT_N - 1));
  assign mem_req     = busy && is_mem_op(op_q);
  assign mem_we      = busy && (op_q == OP_VST);
  assign mem_addr    = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      beat   <= '0;
      done   <= 1'b0;
      op_q   <= '0;
      vd_q   <= '0;
      vs1_q  <= '0;
      vs2_q  <= '0;
      sr_q   <= '0;
      addr_q <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        op_q   <= instr_op;
        vd_q   <= instr_vd;
        vs1_q  <= instr_vs1;
        vs2_q  <= instr_vs2;
        sr_q   <= instr_sr;
        addr_q <= instr_addr;
        beat   <= '0;
        if (is_vec_op(instr_op)) busy <= 1'b1;
        else                     done <= 1'b1;
      end else if (busy) begin
        addr_q <= addr_q + AW'(BEAT);
        if (last_beat) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          beat <= beat + 1'b1;
        end
      end
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n) last_beat |=> done);
  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_vec_op(instr_op)) |=> !instr_ready);
  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !last_beat) |=> (mem_addr == $past(mem_addr) + AW'(BEAT)));
endmodule

// File: rtl/vmu_vrf.sv
module vmu_vrf #(
  parameter int NV   = 4,
  parameter int VLEN = 64,
  parameter int EW   = 16,
  parameter int BEAT = 4,
  parameter int CW   = 4,
  parameter int VI   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CW-1:0]      beat,
  input  logic [VI-1:0]      rd_a_idx,
  input  logic [VI-1:0]      rd_b_idx,
  output logic [BEAT*EW-1:0] rd_a_data,
  output logic [BEAT*EW-1:0] rd_b_data,
  input  logic [VI-1:0]      wr_idx,
  input  logic [BEAT-1:0]    wr_en,
  input  logic [BEAT*EW-1:0] wr_data
);
  localparam int EI = $clog2(VLEN);

  logic [EW-1:0] regs [NV][VLEN];

  for (genvar j = 0; j < BEAT; j++) begin : g_rd
    assign rd_a_data[j*EW +: EW] = regs[rd_a_idx][EI'(int'(beat) * BEAT + j)];
    assign rd_b_data[j*EW +: EW] = regs[rd_b_idx][EI'(int'(beat) * BEAT + j)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NV; r++)
        for (int e = 0; e < VLEN; e++)
          regs[r][e] <= '0;
    end else begin
      for (int j = 0; j < BEAT; j++)
        if (wr_en[j]) regs[wr_idx][EI'(int'(beat) * BEAT + j)] <= wr_data[j*EW +: EW];
    end
  end
endmodule

// File: rtl/vmu_lanes.sv
module vmu_lanes #(
  parameter int EW   = 16,
  parameter int BEAT = 4
) (
  input  logic               masked,
  input  logic [BEAT-1:0]    mask,
  input  logic [BEAT*EW-1:0] a,
  input  logic [BEAT*EW-1:0] b,
  output logic [BEAT*EW-1:0] sum,
  output logic [BEAT-1:0]    wen
);
  function automatic logic [EW-1:0] wrap_add(input logic [EW-1:0] x, input logic [EW-1:0] y);
    return x + y;
  endfunction

  for (genvar j = 0; j < BEAT; j++) begin : g_lane
    assign sum[j*EW +: EW] = wrap_add(a[j*EW +: EW], b[j*EW +: EW]);
    assign wen[j]          = masked ? mask[j] : 1'b1;
  end
endmodule

// File: rtl/vec_mask_alu.sv
module vec_mask_alu #(
  parameter int NV   = 4,
  parameter int NS   = 4,
  parameter int VLEN = 64,
  parameter int EW   = 16,
  parameter int BEAT = 4,
  parameter int AW   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  output logic               instr_ready,
  input  logic [2:0]         instr_op,
  input  logic [$clog2(NV)-1:0] instr_vd,
  input  logic [$clog2(NV)-1:0] instr_vs1,
  input  logic [$clog2(NV)-1:0] instr_vs2,
  input  logic [$clog2(NS)-1:0] instr_sr,
  input  logic [AW-1:0]      instr_addr,
  input  logic [VLEN-1:0]    instr_imm,
  output logic               mem_req,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [BEAT*EW-1:0] mem_wdata,
  input  logic [BEAT*EW-1:0] mem_rdata,
  output logic               done
);
  import vmu_pkg::*;

  localparam int BEAT_N = VLEN / BEAT;
  localparam int CW     = $clog2(BEAT_N);
  localparam int VI     = $clog2(NV);
  localparam int SI     = $clog2(NS);

  logic               accept, busy, last_beat;
  logic [CW-1:0]      beat;
  logic [2:0]         op_q;
  logic [VI-1:0]      vd_q, vs1_q, vs2_q;
  logic [SI-1:0]      sr_q;
  logic [BEAT*EW-1:0] src_a, src_b, lane_sum, wr_data;
  logic [BEAT-1:0]    lane_wen, wr_en, beat_mask;
  logic [VLEN-1:0]    sregs [NS];
  logic [VLEN-1:0]    cur_mask;

  vmu_ctrl #(.AW(AW), .BEAT(BEAT), .BEAT_N(BEAT_N), .CW(CW), .VI(VI), .SI(SI)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
    .instr_vd(instr_vd), .instr_vs1(instr_vs1), .instr_vs2(instr_vs2),
    .instr_sr(instr_sr), .instr_addr(instr_addr), .instr_ready(instr_ready),
    .accept(accept), .busy(busy), .last_beat(last_beat), .beat(beat),
    .op_q(op_q), .vd_q(vd_q), .vs1_q(vs1_q), .vs2_q(vs2_q), .sr_q(sr_q),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .done(done)
  );

  vmu_vrf #(.NV(NV), .VLEN(VLEN), .EW(EW), .BEAT(BEAT), .CW(CW), .VI(VI)) u_vrf (
    .clk(clk), .rst_n(rst_n), .beat(beat),
    .rd_a_idx(vs1_q), .rd_b_idx(vs2_q), .rd_a_data(src_a), .rd_b_data(src_b),
    .wr_idx(vd_q), .wr_en(wr_en), .wr_data(wr_data)
  );

  assign cur_mask  = sregs[sr_q];
  assign beat_mask = cur_mask[int'(beat) * BEAT +: BEAT];

  vmu_lanes #(.EW(EW), .BEAT(BEAT)) u_lanes (
    .masked(op_q == OP_VADDM), .mask(beat_mask), .a(src_a), .b(src_b),
    .sum(lane_sum), .wen(lane_wen)
  );

  always_comb begin
    wr_en   = '0;
    wr_data = lane_sum;
    if (busy && op_q == OP_VLD) begin
      wr_en   = '1;
      wr_data = mem_rdata;
    end else if (busy && is_add_op(op_q)) begin
      wr_en   = lane_wen;
    end
  end

  assign mem_wdata = src_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++) sregs[s] <= '0;
    end else if (accept && instr_op == OP_SETS) begin
      sregs[instr_sr] <= instr_imm;
    end
  end

  // R4
  we_req_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> mem_req);
  // R10
  no_mem_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) instr_ready |-> !mem_req);
  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_VADDM) |-> ((wr_en & ~beat_mask) == '0));
endmodule

// File: tb/vec_mask_alu_bench.sv
`timescale 1ns/1ps
module vec_mask_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [2:0]  instr_op = '0;
  logic [1:0]  instr_vd = '0, instr_vs1 = '0, instr_vs2 = '0, instr_sr = '0;
  logic [15:0] instr_addr = '0;
  logic [63:0] instr_imm = '0;
  logic        mem_req, mem_we, done;
  logic [15:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  logic [15:0] bmem [1024];
  logic [15:0] mv [4][64];
  logic [63:0] ms [4];

  always #2 clk = ~clk;

  vec_mask_alu u_vec_mask_alu (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_op(instr_op), .instr_vd(instr_vd), .instr_vs1(instr_vs1), .instr_vs2(instr_vs2),
    .instr_sr(instr_sr), .instr_addr(instr_addr), .instr_imm(instr_imm),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done)
  );

  always_comb begin
    for (int j = 0; j < 4; j++) mem_rdata[j*16 +: 16] = bmem[10'(mem_addr + 16'(j))];
  end

  always @(posedge clk) begin
    if (mem_req && mem_we)
      for (int j = 0; j < 4; j++) bmem[10'(mem_addr + 16'(j))] <= mem_wdata[j*16 +: 16];
  end

  function automatic logic [15:0] exp_add(input logic [15:0] x, input logic [15:0] y);
    logic [16:0] full;
    full = {1'b0, x} + {1'b0, y};
    return full[15:0];
  endfunction

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [1:0] vd, input logic [1:0] vs1,
                       input logic [1:0] vs2, input logic [1:0] sr, input logic [15:0] addr,
                       input logic [63:0] imm, output int n);
    @(negedge clk);
    instr_op = op; instr_vd = vd; instr_vs1 = vs1; instr_vs2 = vs2;
    instr_sr = sr; instr_addr = addr; instr_imm = imm; instr_valid = 1'b1;
    @(posedge clk); #1;
    instr_valid = 1'b0;
    n = 0;
    while (!done && n < 40) begin
      @(posedge clk); #1;
      n++;
    end
    @(posedge clk); #1;
    check(!done, "R8 pulse", done, 0);
    // bench model of the instruction
    case (op)
      3'd0: ms[sr] = imm;
      3'd1: for (int i = 0; i < 64; i++) mv[vd][i] = bmem[10'(addr + 16'(i))];
      3'd3: begin
        logic [15:0] t [64];
        for (int i = 0; i < 64; i++) t[i] = exp_add(mv[vs1][i], mv[vs2][i]);
        for (int i = 0; i < 64; i++) mv[vd][i] = t[i];
      end
      3'd4: begin
        logic [15:0] t [64];
        for (int i = 0; i < 64; i++) t[i] = ms[sr][i] ? exp_add(mv[vs1][i], mv[vs2][i]) : mv[vd][i];
        for (int i = 0; i < 64; i++) mv[vd][i] = t[i];
      end
      default: ;
    endcase
  endtask

  task automatic check_vreg(input int r, input string req);
    int n, bad, first;
    for (int i = 0; i < 64; i++) bmem[700 + i] = 16'hDEAD;
    issue(3'd2, 2'd0, 2'(r), 2'd0, 2'd0, 16'd700, 64'd0, n);
    check(n == 16, "R8 store cycles", n, 16);
    bad = 0; first = -1;
    for (int i = 0; i < 64; i++)
      if (bmem[700 + i] !== mv[r][i]) begin
        bad++;
        if (first < 0) first = i;
      end
    if (first < 0) check(1'b1, req, 0, 0);
    else check(1'b0, req, bmem[700 + first], mv[r][first]);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        tests++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    int n;
    void'($urandom(32'd2024));
    for (int i = 0; i < 1024; i++) bmem[i] = 16'($urandom);
    for (int r = 0; r < 4; r++) begin
      ms[r] = '0;
      for (int i = 0; i < 64; i++) mv[r][i] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(instr_ready == 1'b1, "R1 ready", instr_ready, 1);
    check(done == 1'b0, "R1 done", done, 0);
    check(mem_req == 1'b0, "R1 mem_req", mem_req, 0);
    @(negedge clk); rst_n = 1'b1;
    check_vreg(2, "R1 vreg zero");

    // R3 loads, aligned and unaligned, with beat count
    issue(3'd1, 2'd0, 2'd0, 2'd0, 2'd0, 16'd0, 64'd0, n);
    check(n == 16, "R8 load cycles", n, 16);
    issue(3'd1, 2'd1, 2'd0, 2'd0, 2'd0, 16'd64, 64'd0, n);
    issue(3'd1, 2'd2, 2'd0, 2'd0, 2'd0, 16'd130, 64'd0, n);
    issue(3'd1, 2'd3, 2'd0, 2'd0, 2'd0, 16'd7, 64'd0, n);
    for (int r = 0; r < 4; r++) check_vreg(r, "R3 R4 load/store");

    // R7 scalar write, done next cycle
    issue(3'd0, 2'd0, 2'd0, 2'd0, 2'd0, 16'd0, 64'hA5C3_0F0F_1234_8001, n);
    check(n == 0, "R7 R8 scalar done", n, 0);
    // R6 random mask
    issue(3'd4, 2'd3, 2'd0, 2'd1, 2'd0, 16'd0, 64'd0, n);
    check(n == 16, "R8 masked cycles", n, 16);
    check_vreg(3, "R6 random mask");
    // R6 zero mask leaves destination
    issue(3'd0, 2'd0, 2'd0, 2'd0, 2'd1, 16'd0, 64'd0, n);
    issue(3'd4, 2'd2, 2'd0, 2'd1, 2'd1, 16'd0, 64'd0, n);
    check_vreg(2, "R6 zero mask");
    // R6 full mask equals plain add
    issue(3'd0, 2'd0, 2'd0, 2'd0, 2'd2, 16'd0, 64'hFFFF_FFFF_FFFF_FFFF, n);
    issue(3'd4, 2'd2, 2'd0, 2'd1, 2'd2, 16'd0, 64'd0, n);
    check_vreg(2, "R6 full mask");

    // R5 wrap-around
    for (int i = 0; i < 64; i++) begin
      bmem[300 + i] = 16'hFFFF;
      bmem[400 + i] = 16'(i + 1);
    end
    issue(3'd1, 2'd0, 2'd0, 2'd0, 2'd0, 16'd300, 64'd0, n);
    issue(3'd1, 2'd1, 2'd0, 2'd0, 2'd0, 16'd400, 64'd0, n);
    issue(3'd3, 2'd2, 2'd0, 2'd1, 2'd0, 16'd0, 64'd0, n);
    check(n == 16, "R8 add cycles", n, 16);
    check_vreg(2, "R5 wrap add");

    // R9 destination aliases source
    issue(3'd3, 2'd1, 2'd1, 2'd1, 2'd0, 16'd0, 64'd0, n);
    check_vreg(1, "R9 alias add");
    issue(3'd4, 2'd0, 2'd0, 2'd2, 2'd0, 16'd0, 64'd0, n);
    check_vreg(0, "R9 alias masked");

    // R10 undefined op codes
    for (int k = 5; k < 8; k++) begin
      issue(3'(k), 2'd1, 2'd2, 2'd3, 2'd0, 16'd0, 64'hFFFF, n);
      check(n == 0, "R10 R8 undefined done", n, 0);
    end
    check_vreg(1, "R10 no change");
    issue(3'd4, 2'd3, 2'd0, 2'd1, 2'd0, 16'd0, 64'd0, n);
    check_vreg(3, "R10 mask unchanged");

    // R2 instructions offered while busy are ignored
    @(negedge clk);
    instr_op = 3'd1; instr_vd = 2'd2; instr_addr = 16'd50; instr_valid = 1'b1;
    @(posedge clk); #1;
    for (int i = 0; i < 64; i++) mv[2][i] = bmem[50 + i];
    instr_op = 3'd3; instr_vd = 2'd3; instr_vs1 = 2'd0; instr_vs2 = 2'd1;
    for (int c = 0; c < 6; c++) begin
      check(instr_ready == 1'b0, "R2 ready low", instr_ready, 0);
      @(posedge clk); #1;
    end
    instr_valid = 1'b0;
    while (!done) begin @(posedge clk); #1; end
    check_vreg(3, "R2 ignored while busy");
    check_vreg(2, "R2 load completes");

    // random mix
    for (int t = 0; t < 40; t++) begin
      int sel;
      sel = int'($urandom % 4);
      case (sel)
        0: issue(3'd0, 2'd0, 2'd0, 2'd0, 2'($urandom), 16'd0, {$urandom, $urandom}, n);
        1: issue(3'd1, 2'($urandom), 2'd0, 2'd0, 2'd0, 16'($urandom % 500), 64'd0, n);
        2: issue(3'd3, 2'($urandom), 2'($urandom), 2'($urandom), 2'd0, 16'd0, 64'd0, n);
        default: issue(3'd4, 2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom), 16'd0, 64'd0, n);
      endcase
    end
    for (int r = 0; r < 4; r++) check_vreg(r, "R5 R6 random mix");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule